// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte type-0 configuration header of one PCI endpoint function. A host-side agent sends one request at a time. Each request is a read or a write of 1, 2 or 4 bytes at a byte offset into the header. The block answers with a one-cycle completion pulse. For reads the completion carries the data. For a bad access it carries an error flag instead. The vendor, device, class, subsystem, header-type and interrupt-pin identity fields come from parameters and cannot be written. The command word, cache line size, latency timer, interrupt line, six base address registers and the expansion ROM register can be written.

Each base address register (BAR) has a size parameter. The size is either zero, which means the BAR is not implemented, or a power of two. Any other size value stops elaboration. A BAR supports size discovery: writing all ones to it loads the inverted size mask. The type bits at the bottom of a BAR are read-only. From the BAR contents the block decodes up to six address windows. For each window it drives an enable, a base address (shifted by a fixed I/O or memory space base) and a length. It pulses a change flag whenever any window moves, so that downstream decoders know to sample the windows again.

The request side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops for the single cycle in which the completion is shown. A requester must therefore hold its request stable until it is taken, and it can issue at most one request every two cycles. The response side has no back-pressure: `rsp_done` is a pulse that lasts one cycle and must be captured when it appears.

Top module: `pcihdr_cfg_space`

## Requirements
- R1: After reset, every header byte reads back as follows. The identity fields hold their parameter values and status holds its parameter value. Command, cache line size, latency timer, the cardbus pointer, the reserved dwords and the expansion ROM read zero, and the interrupt line holds its parameter value. Each BAR reads zero, except an implemented I/O BAR, which reads 0x00000001. No window is enabled.
- R2: `req_ready` is high while idle. A request accepted on a clock edge gives `rsp_done` high for exactly the next cycle, and `req_ready` is low during that cycle.
- R3: A read of 1, 2 or 4 bytes at any offset from 0x00 to 0x3F returns the header bytes in little-endian order. The byte at the request offset lands in `rsp_rdata[7:0]`. Lanes beyond the access size read zero, and bytes past offset 0x3F read zero. Writes complete with `rsp_rdata` zero.
- R4: An access at offset 0x40 or above, or with a size code other than 1, 2 or 4, completes with `rsp_err` high and `rsp_rdata` zero, and it changes no register.
- R5: A 4-byte write of 0xFFFFFFFF to an implemented BAR (offset 0x10 + 4·i) makes it read back as ~(size−1) in the bits above its type bits. Its type bits keep their value.
- R6: The type bits of a BAR are read-only. These are bits [1:0] for an I/O BAR (bit 0 reads 1) and bits [3:0] for a memory BAR. The bits above them take the written value. Writes of other sizes to a BAR have no effect.
- R7: A BAR whose size parameter is zero always reads zero, and its window is never enabled.
- R8: Window i (`win_en[i]`, `win_base[32i+31:32i]`, `win_size[32i+31:32i]`) is enabled when the BAR is implemented and its address bits are nonzero. Its base is those address bits plus the I/O space base or the memory space base, chosen by the BAR type, taken modulo 2^32. Its size is the BAR size parameter.
- R9: `range_changed` is high in the completion cycle of a write that changes any window's enable or base. It is low in every other cycle.
- R10: A 4-byte write of 0xFFFFFFFE to the expansion ROM register (offset 0x30) makes it read 0xFFFFFFFF. Any other 4-byte value is stored as written.
- R11: 1-byte writes take effect only at the interrupt line (0x3C), cache line size (0x0C) and latency timer (0x0D). A 2-byte write at 0x0C loads both the cache line size and the latency timer. A byte write anywhere else, including the interrupt pin, grant, latency limit, revision and ID bytes, has no effect.
- R12: A 2-byte or 4-byte write at offset 0x04 loads the command word from the write data bits [15:0]. The status word at 0x06 is not changed by any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| req_wdata | input | 32 | Write data, little-endian from the offset |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an error (valid with rsp_done) |
| rsp_rdata | output | 32 | Read data (valid with rsp_done) |
| win_en | output | 6 | Per-BAR window enable |
| win_base | output | 192 | Per-BAR window base, 32 bits per BAR |
| win_size | output | 192 | Per-BAR window length, 32 bits per BAR |
| range_changed | output | 1 | One-cycle pulse when any window changed |

## Verification
Reads are swept over every offset from 0x00 to 0x3F at all three legal sizes. This separates lane ordering from field placement, and it shows the zero fill past the end of the header. Byte and halfword writes are then swept over every offset. This separates the few writable bytes from the read-only ones, and it shows that sub-word writes never reach a BAR. Each BAR is then driven through a sizing probe, an address pattern that also tries to flip the type bits, a repeat of the same value and a clear. This pattern tells the I/O mask from the memory mask and an implemented BAR from an unimplemented one, and it tells a real window move from a write that changes nothing. Illegal offsets and size codes are mixed in, including a bad-size write aimed at a writable byte, to show that errors leave all state untouched.

// File: rtl/pcihdr_pkg.sv
package pcihdr_pkg;

  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;
  localparam int HDR_DW    = HDR_BYTES / 4;

  // Header offsets that software decodes; positions fixed by the bus standard.
  localparam logic [7:0] OFF_CMD      = 8'h04;
  localparam logic [7:0] OFF_CACHELN  = 8'h0C;
  localparam logic [7:0] OFF_LATTMR   = 8'h0D;
  localparam logic [7:0] OFF_BAR_BASE = 8'h10;
  localparam logic [7:0] OFF_ROM      = 8'h30;
  localparam logic [7:0] OFF_INTLINE  = 8'h3C;

  localparam logic [31:0] TYPE_MASK_IO  = 32'h0000_0003;
  localparam logic [31:0] TYPE_MASK_MEM = 32'h0000_000F;
  localparam logic [31:0] SIZE_PROBE    = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE     = 32'hFFFF_FFFE;

  function automatic logic size_is_legal(logic [31:0] v);
    return (v & (v - 32'd1)) == 32'd0;
  endfunction

  function automatic logic access_size_ok(logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/pcihdr_bar_slot.sv
module pcihdr_bar_slot
  import pcihdr_pkg::*;
#(
  parameter logic [31:0] SIZE     = 32'h0000_1000,
  parameter bit          IS_IO    = 1'b0,
  parameter logic [31:0] IO_BASE  = 32'h8000_0000,
  parameter logic [31:0] MEM_BASE = 32'h4000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] bar_value,
  output logic        win_en,
  output logic [31:0] win_base,
  output logic        win_chg
);

  localparam bit          IMPL       = (SIZE != 32'd0);
  localparam logic [31:0] TMASK      = IS_IO ? TYPE_MASK_IO : TYPE_MASK_MEM;
  localparam logic [31:0] SPACE_BASE = IS_IO ? IO_BASE : MEM_BASE;
  localparam logic [31:0] RST_VAL    = (IMPL && IS_IO) ? 32'h1 : 32'h0;

  if (!size_is_legal(SIZE)) begin : g_bad_size
    $error("BAR size parameter must be zero or a power of two");
  end

  logic [31:0] bar_q, bar_d, probe_val;
  logic [31:0] addr_q, addr_d;
  logic        en_d;

  always_comb begin
    probe_val = (wdata == SIZE_PROBE) ? ~(SIZE - 32'd1) : wdata;
    if (!IMPL)       bar_d = 32'd0;
    else if (wr_en)  bar_d = (probe_val & ~TMASK) | (bar_q & TMASK);
    else             bar_d = bar_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bar_q <= RST_VAL;
    else        bar_q <= bar_d;
  end

  assign addr_q   = bar_q & ~TMASK;
  assign addr_d   = bar_d & ~TMASK;
  assign en_d     = IMPL && (addr_d != 32'd0);
  assign win_en   = IMPL && (addr_q != 32'd0);
  assign win_base = addr_q + SPACE_BASE;
  assign win_chg  = (en_d != win_en) || ((addr_d + SPACE_BASE) != win_base);
  assign bar_value = bar_q;

endmodule

// File: rtl/pcihdr_read_mux.sv
module pcihdr_read_mux
  import pcihdr_pkg::*;
(
  input  logic [HDR_BYTES*8-1:0] img,
  input  logic [7:0]             offset,
  input  logic [2:0]             size,
  output logic [31:0]            rdata
);

  always_comb begin
    rdata = 32'd0;
    for (int k = 0; k < 4; k++) begin
      if ((k < int'(size)) && ((int'(offset) + k) < HDR_BYTES))
        rdata[k*8 +: 8] = img[(int'(offset) + k)*8 +: 8];
    end
  end

endmodule

// File: rtl/pcihdr_cfg_space.sv
module pcihdr_cfg_space
  import pcihdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1AB4,
  parameter logic [15:0] DEVICE_ID     = 16'h0C21,
  parameter logic [15:0] STATUS_INIT   = 16'h0000,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [7:0]  SUBCLASS      = 8'h80,
  parameter logic [7:0]  CLASS_CODE    = 8'h02,
  parameter logic [7:0]  HEADER_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000,
  parameter logic [7:0]  INT_LINE_INIT = 8'h00,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h00,
  parameter logic [7:0]  MAX_LAT       = 8'h00,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES = {32'h0, 32'h0, 32'h0, 32'h0,
                                                 32'h0000_0100, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0]    BAR_IS_IO = 6'b000010,
  parameter logic [31:0] IO_BASE       = 32'h8000_0000,
  parameter logic [31:0] MEM_BASE      = 32'h4000_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [7:0]               req_offset,
  input  logic [2:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_done,
  output logic                     rsp_err,
  output logic [31:0]              rsp_rdata,
  output logic [NUM_BARS-1:0]      win_en,
  output logic [NUM_BARS*32-1:0]   win_base,
  output logic [NUM_BARS*32-1:0]   win_size,
  output logic                     range_changed
);

  logic        accept, bad, wr_ok;
  logic        sz1, sz2, sz4;
  logic        done_q, err_q, chg_q;
  logic [31:0] rdata_q, mux_rdata;
  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, intl_q;
  logic [31:0] rom_q;
  logic [31:0] bar_val [NUM_BARS];
  logic [NUM_BARS-1:0] bar_chg;
  logic [31:0] hdr_dw [HDR_DW];
  logic [HDR_BYTES*8-1:0] img;

  assign req_ready = !done_q;
  assign accept    = req_valid && req_ready;
  assign bad       = (req_offset >= 8'(HDR_BYTES)) || !access_size_ok(req_size);
  assign wr_ok     = accept && req_write && !bad;
  assign sz1       = (req_size == 3'd1);
  assign sz2       = (req_size == 3'd2);
  assign sz4       = (req_size == 3'd4);

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    logic bar_we;
    assign bar_we = wr_ok && sz4 && (req_offset == OFF_BAR_BASE + 8'(4*i));
    pcihdr_bar_slot #(
      .SIZE     (BAR_SIZES[i*32 +: 32]),
      .IS_IO    (BAR_IS_IO[i]),
      .IO_BASE  (IO_BASE),
      .MEM_BASE (MEM_BASE)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bar_we),
      .wdata     (req_wdata),
      .bar_value (bar_val[i]),
      .win_en    (win_en[i]),
      .win_base  (win_base[i*32 +: 32]),
      .win_chg   (bar_chg[i])
    );
    assign win_size[i*32 +: 32] = BAR_SIZES[i*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 16'd0;
      cls_q  <= 8'd0;
      lat_q  <= 8'd0;
      intl_q <= INT_LINE_INIT;
      rom_q  <= 32'd0;
    end else if (wr_ok) begin
      if ((sz2 || sz4) && req_offset == OFF_CMD)
        cmd_q <= req_wdata[15:0];
      if ((sz1 || sz2) && req_offset == OFF_CACHELN)
        cls_q <= req_wdata[7:0];
      if (sz1 && req_offset == OFF_LATTMR)
        lat_q <= req_wdata[7:0];
      else if (sz2 && req_offset == OFF_CACHELN)
        lat_q <= req_wdata[15:8];
      if (sz1 && req_offset == OFF_INTLINE)
        intl_q <= req_wdata[7:0];
      if (sz4 && req_offset == OFF_ROM)
        rom_q <= (req_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : req_wdata;
    end
  end

  always_comb begin
    for (int d = 0; d < HDR_DW; d++) hdr_dw[d] = 32'd0;
    hdr_dw[0]  = {DEVICE_ID, VENDOR_ID};
    hdr_dw[1]  = {STATUS_INIT, cmd_q};
    hdr_dw[2]  = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
    hdr_dw[3]  = {8'h00, HEADER_TYPE, lat_q, cls_q};
    for (int b = 0; b < NUM_BARS; b++) hdr_dw[4 + b] = bar_val[b];
    hdr_dw[11] = {SUBSYS_ID, SUBSYS_VENDOR};
    hdr_dw[12] = rom_q;
    hdr_dw[15] = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
  end

  for (genvar d = 0; d < HDR_DW; d++) begin : g_img
    assign img[d*32 +: 32] = hdr_dw[d];
  end

  pcihdr_read_mux u_rmux (
    .img    (img),
    .offset (req_offset),
    .size   (req_size),
    .rdata  (mux_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= 32'd0;
      chg_q   <= 1'b0;
    end else begin
      done_q  <= accept;
      err_q   <= accept && bad;
      rdata_q <= (accept && !bad && !req_write) ? mux_rdata : 32'd0;
      chg_q   <= |bar_chg;
    end
  end

  assign rsp_done      = done_q;
  assign rsp_err       = err_q;
  assign rsp_rdata     = rdata_q;
  assign range_changed = chg_q;

endmodule

// File: rtl/pcihdr_cfg_chk.sv
module pcihdr_cfg_chk
  import pcihdr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [7:0]             req_offset,
  input logic [2:0]             req_size,
  input logic                   rsp_done,
  input logic                   rsp_err,
  input logic [31:0]            rsp_rdata,
  input logic [NUM_BARS-1:0]    win_en,
  input logic [NUM_BARS*32-1:0] win_base,
  input logic                   range_changed
);

  AST_ACCEPT_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_done); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R2
  AST_ERR_HIGH_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_offset >= 8'(HDR_BYTES)) |=> rsp_err); // R4
  AST_ERR_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4)
      |=> rsp_err); // R4
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_done && rsp_rdata == 32'd0)); // R4
  AST_RANGE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    range_changed |-> rsp_done); // R9
  AST_WIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !range_changed |-> ($stable(win_en) && $stable(win_base))); // R9
  AST_RANGE_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    range_changed |-> (win_en != $past(win_en) || win_base != $past(win_base))); // R9

endmodule

bind pcihdr_cfg_space pcihdr_cfg_chk u_cfg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_offset    (req_offset),
  .req_size      (req_size),
  .rsp_done      (rsp_done),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .win_en        (win_en),
  .win_base      (win_base),
  .range_changed (range_changed)
);

// File: tb/test_pcihdr_cfg_space.sv
module test_pcihdr_cfg_space;
  import pcihdr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] P_VID = 16'hABCD, P_DID = 16'h1357, P_STAT = 16'h0210;
  localparam logic [7:0]  P_REV = 8'h05, P_PIF = 8'h11, P_SUB = 8'h22, P_CLS = 8'h33;
  localparam logic [7:0]  P_HDR = 8'h00, P_ILN = 8'h0B, P_IPN = 8'h02;
  localparam logic [7:0]  P_MGN = 8'h44, P_MLT = 8'h55;
  localparam logic [15:0] P_SSV = 16'h6677, P_SSI = 16'h8899;
  localparam logic [NUM_BARS*32-1:0] P_SIZES = {32'h0100_0000, 32'h0000_0020, 32'h0000_0010,
                                                32'h0000_0000, 32'h0000_0100, 32'h0000_1000};
  localparam logic [NUM_BARS-1:0] P_IO = 6'b010010;
  localparam logic [31:0] P_IOB = 32'h8000_0000, P_MEMB = 32'hF000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = 8'd0;
  logic [2:0]  req_size = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic req_ready, rsp_done, rsp_err, range_changed;
  logic [31:0] rsp_rdata;
  logic [NUM_BARS-1:0] win_en;
  logic [NUM_BARS*32-1:0] win_base, win_size;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] m [HDR_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcihdr_cfg_space #(
    .VENDOR_ID(P_VID), .DEVICE_ID(P_DID), .STATUS_INIT(P_STAT), .REVISION(P_REV),
    .PROG_IF(P_PIF), .SUBCLASS(P_SUB), .CLASS_CODE(P_CLS), .HEADER_TYPE(P_HDR),
    .SUBSYS_VENDOR(P_SSV), .SUBSYS_ID(P_SSI), .INT_LINE_INIT(P_ILN), .INT_PIN(P_IPN),
    .MIN_GNT(P_MGN), .MAX_LAT(P_MLT), .BAR_SIZES(P_SIZES), .BAR_IS_IO(P_IO),
    .IO_BASE(P_IOB), .MEM_BASE(P_MEMB)
  ) i_pcihdr_cfg_space (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .win_en(win_en), .win_base(win_base),
    .win_size(win_size), .range_changed(range_changed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdw(int o);
    return {m[o+3], m[o+2], m[o+1], m[o]};
  endfunction

  task automatic mset(int o, logic [31:0] v);
    for (int k = 0; k < 4; k++) m[o+k] = v[k*8 +: 8];
  endtask

  function automatic logic [31:0] bsize(int i);
    return P_SIZES[i*32 +: 32];
  endfunction

  function automatic logic [31:0] tmask(int i);
    return P_IO[i] ? 32'h3 : 32'hF;
  endfunction

  function automatic logic men(int i);
    return (bsize(i) != 0) && ((mdw(16 + 4*i) & ~tmask(i)) != 0);
  endfunction

  function automatic logic [31:0] mbase(int i);
    return (mdw(16 + 4*i) & ~tmask(i)) + (P_IO[i] ? P_IOB : P_MEMB);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < HDR_BYTES; b++) m[b] = 8'h00;
    mset(0,  {P_DID, P_VID});
    mset(4,  {P_STAT, 16'h0000});
    mset(8,  {P_CLS, P_SUB, P_PIF, P_REV});
    mset(12, {8'h00, P_HDR, 8'h00, 8'h00});
    for (int i = 0; i < NUM_BARS; i++)
      mset(16 + 4*i, (bsize(i) != 0 && P_IO[i]) ? 32'h1 : 32'h0);
    mset(44, {P_SSI, P_SSV});
    mset(60, {P_MLT, P_MGN, P_IPN, P_ILN});
  endtask

  task automatic model_write(int off, int sz, logic [31:0] wd);
    logic [31:0] nv, old;
    if (sz == 1 && (off == 12 || off == 13 || off == 60)) m[off] = wd[7:0];
    if (sz == 2 && (off == 4 || off == 12)) begin
      m[off] = wd[7:0]; m[off+1] = wd[15:8];
    end
    if (sz == 4 && off == 4) begin
      m[4] = wd[7:0]; m[5] = wd[15:8];
    end
    if (sz == 4 && off >= 16 && off <= 36 && (off % 4) == 0) begin
      int i = (off - 16) / 4;
      old = mdw(off);
      nv  = (wd == 32'hFFFF_FFFF) ? ~(bsize(i) - 1) : wd;
      mset(off, (bsize(i) == 0) ? 32'h0 : ((nv & ~tmask(i)) | (old & tmask(i))));
    end
    if (sz == 4 && off == 48) mset(48, (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd);
  endtask

  task automatic xfer(input string tag, input logic wr, input int off, input int sz,
                      input logic [31:0] wd);
    logic e_err, e_rc;
    logic [31:0] e_rd;
    logic [NUM_BARS-1:0] en_b;
    logic [31:0] base_b [NUM_BARS];
    e_err = (off >= HDR_BYTES) || !(sz == 1 || sz == 2 || sz == 4);
    e_rd = 32'd0;
    if (!e_err && !wr)
      for (int k = 0; k < sz; k++)
        if (off + k < HDR_BYTES) e_rd |= 32'(m[off+k]) << (8*k);
    for (int i = 0; i < NUM_BARS; i++) begin en_b[i] = men(i); base_b[i] = mbase(i); end
    if (wr && !e_err) model_write(off, sz, wd);
    e_rc = 1'b0;
    for (int i = 0; i < NUM_BARS; i++)
      if (en_b[i] != men(i) || base_b[i] != mbase(i)) e_rc = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off[7:0];
    req_size = sz[2:0]; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 done"}, {31'd0, rsp_done}, 32'd1);
    chk({tag, " R2 ready low"}, {31'd0, req_ready}, 32'd0);
    chk({tag, " err"}, {31'd0, rsp_err}, {31'd0, e_err});
    chk({tag, " rdata"}, rsp_rdata, e_rd);
    chk({tag, " R9 range_changed"}, {31'd0, range_changed}, {31'd0, e_rc});
    for (int i = 0; i < NUM_BARS; i++) begin
      chk({tag, " R8 win_en"}, {31'd0, win_en[i]}, {31'd0, men(i)});
      if (men(i)) chk({tag, " R8 win_base"}, win_base[i*32 +: 32], mbase(i));
      chk({tag, " R8 win_size"}, win_size[i*32 +: 32], bsize(i));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 done", {31'd0, rsp_done}, 32'd0);
    chk("R1 range", {31'd0, range_changed}, 32'd0);
    chk("R1 win_en", {26'd0, win_en}, 32'd0);
    // R1, R3: read sweep of the reset image at every offset and size
    for (int o = 0; o < HDR_BYTES; o++) begin
      xfer("R1 R3 rd1", 1'b0, o, 1, 32'd0);
      xfer("R3 rd2", 1'b0, o, 2, 32'd0);
      xfer("R3 rd4", 1'b0, o, 4, 32'd0);
    end
    // R4: illegal offsets and size codes
    for (int o = 64; o < 80; o++) xfer("R4 offset", 1'b0, o, 4, 32'd0);
    xfer("R4 offset ff", 1'b0, 255, 1, 32'd0);
    for (int s = 0; s < 8; s++)
      if (s == 0 || s == 3 || s >= 5) xfer("R4 size", 1'b0, 8, s, 32'd0);
    xfer("R4 bad write", 1'b1, 60, 3, 32'h0000_00FF);
    xfer("R4 bad write hi", 1'b1, 64, 4, 32'hFFFF_FFFF);
    xfer("R4 check intline", 1'b0, 60, 1, 32'd0);
    // R11: byte writes across the whole header, then read back
    for (int o = 0; o < HDR_BYTES; o++)
      xfer("R11 wr1", 1'b1, o, 1, 32'(o ^ 8'hA5));
    for (int o = 0; o < HDR_BYTES; o += 4) xfer("R11 readback", 1'b0, o, 4, 32'd0);
    // R12, R11: halfword writes across the header
    for (int o = 0; o < HDR_BYTES; o++)
      xfer("R12 wr2", 1'b1, o, 2, 32'(16'h5A00 + o));
    for (int o = 0; o < 16; o += 2) xfer("R12 readback", 1'b0, o, 2, 32'd0);
    xfer("R12 wr4 cmd", 1'b1, 4, 4, 32'hFFFF_BEEF);
    xfer("R12 status kept", 1'b0, 4, 4, 32'd0);
    xfer("R12 status write", 1'b1, 6, 2, 32'h0000_FFFF);
    xfer("R12 status read", 1'b0, 6, 2, 32'd0);
    // R5..R9: per-BAR probe, address, repeat and clear
    for (int i = 0; i < NUM_BARS; i++) begin
      int o = 16 + 4*i;
      xfer("R5 R7 probe", 1'b1, o, 4, 32'hFFFF_FFFF);
      xfer("R5 R7 probe rd", 1'b0, o, 4, 32'd0);
      xfer("R6 R7 addr", 1'b1, o, 4, 32'h1234_567E ^ (32'(i) << 24));
      xfer("R6 R7 addr rd", 1'b0, o, 4, 32'd0);
      xfer("R9 repeat", 1'b1, o, 4, 32'h1234_567E ^ (32'(i) << 24));
      xfer("R6 sub-word", 1'b1, o, 2, 32'h0000_FFFF);
      xfer("R6 sub-word rd", 1'b0, o, 4, 32'd0);
      xfer("R8 clear", 1'b1, o, 4, 32'h0000_0000);
      xfer("R8 clear rd", 1'b0, o, 4, 32'd0);
      xfer("R8 reprogram", 1'b1, o, 4, 32'hC000_0000 | (32'(i) << 12));
    end
    // R10: expansion ROM register
    xfer("R10 probe", 1'b1, 48, 4, 32'hFFFF_FFFE);
    xfer("R10 probe rd", 1'b0, 48, 4, 32'd0);
    xfer("R10 store", 1'b1, 48, 4, 32'h1234_0001);
    xfer("R10 store rd", 1'b0, 48, 4, 32'd0);
    xfer("R10 all ones", 1'b1, 48, 4, 32'hFFFF_FFFF);
    xfer("R10 all ones rd", 1'b0, 48, 4, 32'd0);
    // R3: final full read sweep of the programmed image
    for (int o = 0; o < HDR_BYTES; o++) xfer("R3 final", 1'b0, o, 4, 32'd0);
    @(negedge clk);
    chk("R9 idle", {31'd0, range_changed}, 32'd0);
    finish_run();
  end

endmodule